// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block is the translation cache of an I/O memory management unit. It holds a parameterised set of entries (32 by default), each mapping one virtual page to a physical page together with a small set of access attributes. Any entry may map a page of one of four sizes (4 KB, 64 KB, 1 MB or 16 MB), and all of them are searched in parallel by a combinational lookup port that returns a hit flag, the translated physical address and the attributes.

Software manages the array through a small register port. It first writes a tag word and a data word into staging registers. A commit strobe then copies both into the entry that the victim pointer selects, and the pointer moves on. A lock register holds a base index and the victim pointer. Entries below the base are never chosen by the automatic advance, so they stay fixed. Software can invalidate the entries that match a staged tag and size, or clear the whole array. The global clear spares entries whose preserve flag is set. The entry under the victim pointer can be read back through the same port.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is invalid, the lock base and victim pointer are 0, every lookup misses with `lk_pa` and `lk_attr` zero, and reads of the tag, data and lock registers return 0.
- R2: Register map on `reg_addr`: 0 tag, 1 data, 2 lock, 3 commit, 4 drop-matching, 5 drop-all. A write to 0 stages the virtual tag from bits 31:12, preserve from bit 3, valid from bit 2 and the size code from bits 1:0. A write to 1 stages the physical tag from bits 31:12, the endian flag from bit 9, the element size from bits 8:7 and the mixed flag from bit 6. A write to 3 with bit 0 set stores both staged words into the entry at the victim pointer. Reads of 0 and 1 return that entry's fields at the same positions, with every other bit zero.
- R3: A commit advances the victim pointer by one. From the last index it returns to the lock base, not to 0.
- R4: The size codes are 0 = 1 MB, 1 = 64 KB, 2 = 4 KB and 3 = 16 MB. A 4 KB entry hits when VA[31:12] equals its tag. The physical address is then the stored tag followed by VA[11:0].
- R5: A 64 KB, 1 MB or 16 MB entry compares only VA[31:16], VA[31:20] or VA[31:24]. The offset bits below that boundary pass from the VA to `lk_pa`.
- R6: When several valid entries hit, the lowest-indexed one supplies `lk_pa` and `lk_attr`.
- R7: An entry whose valid flag is clear never hits.
- R8: A write to 4 with bit 0 set invalidates each valid entry whose size equals the staged size and whose tag matches the staged tag over that size's compared bits. Entries of other sizes are untouched.
- R9: A write to 5 with bit 0 set invalidates every entry whose preserve flag is clear. Preserved entries keep translating.
- R10: The lock register holds the base in bits 4:0 and the victim pointer in bits 12:8. Both are written directly and both are read back. Writes to 3, 4 or 5 with bit 0 clear change nothing.
- R11: `lk_attr` is {endian, element size[1:0], mixed} of the selected entry, and zero on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address, zero on a miss |
| lk_attr | output | 4 | {endian, element size[1:0], mixed}, zero on a miss |

## Verification
The bench loads a large-page entry and a 4 KB entry that overlap, with the large page first. A priority encoder that favoured high indices would return the 4 KB translation at the overlap address. It then commits into the last two slots with a nonzero base. A pointer that wrapped to 0 would read back 0 instead of the base. Drop-matching is tried with a staged size that differs from an entry whose tag matches. A flush that ignored the size would kill the 64 KB mapping. The drop-all test keeps one preserved entry live, so a flush that ignored the preserve flag loses it. Offset bits are checked just inside and just outside each page size, which exposes a mask that is off by one nibble.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W         = 32;
    localparam int PG_LSB       = 12;
    localparam int TAG_W        = VA_W - PG_LSB;
    localparam int LOCK_VIC_LSB = 8;

    typedef enum logic [2:0] {
        RG_TAG      = 3'd0,
        RG_DATA     = 3'd1,
        RG_LOCK     = 3'd2,
        RG_COMMIT   = 3'd3,
        RG_DROP_ONE = 3'd4,
        RG_DROP_ALL = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic [TAG_W-1:0] vtag;
        logic [1:0]       psz;
        logic             vld;
        logic             pres;
        logic [TAG_W-1:0] ptag;
        logic             endi;
        logic [1:0]       esz;
        logic             mix;
    } tlb_ent_t;

    // Bits of the page tag that take part in a compare, per size code
    function automatic logic [TAG_W-1:0] tag_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    tag_mask = 20'hFFF00;
            2'd1:    tag_mask = 20'hFFFF0;
            2'd2:    tag_mask = 20'hFFFFF;
            default: tag_mask = 20'hFF000;
        endcase
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  tlb_ent_t [ENTRIES-1:0] ent,
    input  logic [TAG_W-1:0]       probe_tag,
    input  logic                   size_fixed,
    input  logic [1:0]             probe_size,
    output logic [ENTRIES-1:0]     hits
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [1:0]       use_sz;
        logic [TAG_W-1:0] diff;
        logic             size_ok;
        assign use_sz  = size_fixed ? probe_size : ent[g].psz;
        assign size_ok = !size_fixed || (ent[g].psz == probe_size);
        assign diff    = (ent[g].vtag ^ probe_tag) & tag_mask(use_sz);
        assign hits[g] = ent[g].vld && size_ok && (diff == '0);
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
                grant = '0;
                grant[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] lk_va,
    output logic        lk_hit,
    output logic [31:0] lk_pa,
    output logic [3:0]  lk_attr
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        tlb_ent_t [ENTRIES-1:0] ent;
        tlb_ent_t               stg;
        logic [IDX_W-1:0]       base;
        logic [IDX_W-1:0]       vic;
    } st_t;

    st_t st_d, st_q;

    reg_sel_e sel;
    logic     do_load, do_drop_one, do_drop_all;
    logic     unused_wbits;

    assign sel          = reg_sel_e'(reg_addr);
    assign do_load      = reg_we && (sel == RG_COMMIT)   && reg_wdata[0];
    assign do_drop_one  = reg_we && (sel == RG_DROP_ONE) && reg_wdata[0];
    assign do_drop_all  = reg_we && (sel == RG_DROP_ALL) && reg_wdata[0];
    assign unused_wbits = ^reg_wdata;

    logic [ENTRIES-1:0] lk_match, drop_match, lk_grant;
    logic               lk_found;
    logic [IDX_W-1:0]   lk_idx;

    tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ent        (st_q.ent),
        .probe_tag  (lk_va[31:12]),
        .size_fixed (1'b0),
        .probe_size (2'd0),
        .hits       (lk_match)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_drop_match (
        .ent        (st_q.ent),
        .probe_tag  (st_q.stg.vtag),
        .size_fixed (1'b1),
        .probe_size (st_q.stg.psz),
        .hits       (drop_match)
    );

    tlb_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick (
        .req   (lk_match),
        .found (lk_found),
        .idx   (lk_idx),
        .grant (lk_grant)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            case (sel)
                RG_TAG: begin
                    st_d.stg.vtag = reg_wdata[31:12];
                    st_d.stg.pres = reg_wdata[3];
                    st_d.stg.vld  = reg_wdata[2];
                    st_d.stg.psz  = reg_wdata[1:0];
                end
                RG_DATA: begin
                    st_d.stg.ptag = reg_wdata[31:12];
                    st_d.stg.endi = reg_wdata[9];
                    st_d.stg.esz  = reg_wdata[8:7];
                    st_d.stg.mix  = reg_wdata[6];
                end
                RG_LOCK: begin
                    st_d.base = reg_wdata[IDX_W-1:0];
                    st_d.vic  = reg_wdata[LOCK_VIC_LSB +: IDX_W];
                end
                default: ;
            endcase
        end
        if (do_load) begin
            st_d.ent[st_q.vic] = st_q.stg;
            st_d.vic = (st_q.vic == LAST_IDX) ? st_q.base : st_q.vic + 1'b1;
        end
        if (do_drop_one) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (drop_match[i]) st_d.ent[i].vld = 1'b0;
            end
        end
        if (do_drop_all) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!st_q.ent[i].pres) st_d.ent[i].vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Register readback
    tlb_ent_t rd_ent;
    always_comb begin
        rd_ent    = st_q.ent[st_q.vic];
        reg_rdata = '0;
        case (sel)
            RG_TAG:  reg_rdata = {rd_ent.vtag, 8'd0, rd_ent.pres, rd_ent.vld, rd_ent.psz};
            RG_DATA: reg_rdata = {rd_ent.ptag, 2'd0, rd_ent.endi, rd_ent.esz, rd_ent.mix, 6'd0};
            RG_LOCK: begin
                reg_rdata[IDX_W-1:0]               = st_q.base;
                reg_rdata[LOCK_VIC_LSB +: IDX_W]   = st_q.vic;
            end
            default: reg_rdata = '0;
        endcase
    end

    // Lookup result
    tlb_ent_t         hit_ent;
    logic [TAG_W-1:0] pmask;
    always_comb begin
        hit_ent = st_q.ent[lk_idx];
        pmask   = tag_mask(hit_ent.psz);
        lk_hit  = lk_found;
        lk_pa   = '0;
        lk_attr = '0;
        if (lk_found) begin
            lk_pa   = {(hit_ent.ptag & pmask) | (lk_va[31:12] & ~pmask), lk_va[11:0]};
            lk_attr = {hit_ent.endi, hit_ent.esz, hit_ent.mix};
        end
    end

    // Checks
    logic unpres_live;
    always_comb begin
        unpres_live = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (st_q.ent[i].vld && !st_q.ent[i].pres) unpres_live = 1'b1;
        end
    end

    a_r3_victim_step: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> st_q.vic == (($past(st_q.vic) == LAST_IDX) ? $past(st_q.base)
                                                              : IDX_W'($past(st_q.vic) + 1'b1)));

    a_r2_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> st_q.ent[$past(st_q.vic)] == $past(st_q.stg));

    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_grant) && (lk_hit == (|lk_match)));

    a_r7_hit_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> st_q.ent[lk_idx].vld);

    a_r9_sweep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        do_drop_all |=> !unpres_live);

    a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == '0 && lk_attr == '0));

endmodule

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] lk_va = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic [3:0]  lk_attr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    xlat_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr)
    );

    // {va, hit, pa, attr}
    localparam logic [68:0] LK_VEC [10] = '{
        {32'h12345ABC, 1'b1, 32'hABCDEABC, 4'hC},  // R4 4 KB
        {32'h12346000, 1'b0, 32'h00000000, 4'h0},  // R4 next page misses
        {32'h2000F123, 1'b1, 32'h5555F123, 4'h1},  // R5 64 KB, R11 mixed
        {32'h20010000, 1'b0, 32'h00000000, 4'h0},  // R5 64 KB boundary
        {32'h300ABCDE, 1'b1, 32'h7F1ABCDE, 4'h0},  // R5 1 MB
        {32'h30012345, 1'b1, 32'h7F112345, 4'h0},  // R6 lowest index wins
        {32'h40FFFFFF, 1'b1, 32'h81FFFFFF, 4'h0},  // R5 16 MB
        {32'h41000000, 1'b0, 32'h00000000, 4'h0},  // R5 16 MB boundary
        {32'h50000000, 1'b0, 32'h00000000, 4'h0},  // R7 invalid entry
        {32'h3FF00000, 1'b0, 32'h00000000, 4'h0}   // R5 1 MB neighbour
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic look(input string req, input logic [31:0] va, input logic hit,
                        input logic [31:0] pa, input logic [3:0] attr);
        lk_va = va;
        #1;
        chk(req, {31'd0, lk_hit}, {31'd0, hit});
        chk(req, lk_pa, pa);
        chk(req, {28'd0, lk_attr}, {28'd0, attr});
    endtask

    task automatic put(input logic [31:0] tag, input logic [31:0] data);
        wr(3'd0, tag);
        wr(3'd1, data);
        wr(3'd3, 32'd1);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        look("R1", 32'h00000000, 1'b0, 32'h0, 4'h0);
        rd("R1", 3'd2, 32'h0);
        rd("R1", 3'd0, 32'h0);
        rd("R1", 3'd1, 32'h0);

        put(32'h12345006, 32'hABCDE300);  // 0: 4 KB
        put(32'h20000005, 32'h55550040);  // 1: 64 KB
        put(32'h3000000C, 32'h7F100000);  // 2: 1 MB preserved
        put(32'h40000007, 32'h81000000);  // 3: 16 MB
        put(32'h30012006, 32'h99999000);  // 4: 4 KB overlapping entry 2
        put(32'h50000002, 32'h11111000);  // 5: not valid
        rd("R3", 3'd2, 32'h00000600);

        for (int i = 0; i < 10; i++) begin
            look("R4/R5/R6/R7/R11", LK_VEC[i][68:37], LK_VEC[i][36],
                 LK_VEC[i][35:4], LK_VEC[i][3:0]);
        end

        // R2 / R10 readback at chosen victim
        wr(3'd2, 32'h00000000);
        rd("R2", 3'd0, 32'h12345006);
        rd("R2", 3'd1, 32'hABCDE300);
        wr(3'd2, 32'h00000300);
        rd("R2", 3'd0, 32'h40000007);
        rd("R10", 3'd2, 32'h00000300);

        // R3 wrap to lock base
        wr(3'd2, 32'h00001E1E);
        put(32'h60000006, 32'h60000000);
        rd("R3", 3'd2, 32'h00001F1E);
        put(32'h61000006, 32'h61000000);
        rd("R3", 3'd2, 32'h00001E1E);
        rd("R3", 3'd0, 32'h60000006);
        look("R3", 32'h60000123, 1'b1, 32'h60000123, 4'h0);

        // R10 strobes with bit 0 clear
        wr(3'd3, 32'h0);
        rd("R10", 3'd2, 32'h00001E1E);
        wr(3'd5, 32'h0);
        look("R10", 32'h12345ABC, 1'b1, 32'hABCDEABC, 4'hC);
        wr(3'd0, 32'h30000000);
        wr(3'd4, 32'h0);
        look("R10", 32'h300ABCDE, 1'b1, 32'h7F1ABCDE, 4'h0);

        // R8 drop matching, staged 1 MB tag
        wr(3'd4, 32'h1);
        look("R8", 32'h300ABCDE, 1'b0, 32'h0, 4'h0);
        look("R8", 32'h30012345, 1'b1, 32'h99999345, 4'h0);
        wr(3'd0, 32'h20000002);  // same tag, 4 KB size: 64 KB entry survives
        wr(3'd4, 32'h1);
        look("R8", 32'h2000F123, 1'b1, 32'h5555F123, 4'h1);

        // R9 global drop keeps preserved entry
        wr(3'd2, 32'h00000700);
        put(32'h7000000E, 32'h12300000);
        wr(3'd5, 32'h1);
        look("R9", 32'h70000FFF, 1'b1, 32'h12300FFF, 4'h0);
        look("R9", 32'h12345ABC, 1'b0, 32'h0, 4'h0);
        look("R9", 32'h60000123, 1'b0, 32'h0, 4'h0);
        look("R9", 32'h2000F123, 1'b0, 32'h0, 4'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule